// File: doc/BRIEF.md
# Staggered-Schedule Serial LDPC Decoder

This block decodes one short LDPC codeword using a serial, check-by-check schedule. It stores one signed running soft value per code bit, not one message per graph edge. The values are loaded with the channel LLRs while the block is idle. After a start pulse, the block visits one parity check per clock cycle, in index order. For the active check it takes the current running values of its connected bits. It forms a check-to-bit message for each of those bits and adds that message into the bit's running value straight away. Later checks in the same pass therefore already see the updated values.

Nothing is subtracted for a check's own earlier contribution, so storage grows with the block length and not with the number of edges. The parity-check matrix is fixed when the design is built and is computed from a rule, not stored as a table. When the requested number of passes is finished, the hard decisions are the sign bits of the running values, and a one-cycle done pulse marks them as final.

Top module: `stag_ldpc_dec`

## Requirements
- R1: While idle, a cycle with `ld_en` high writes `ld_llr` (6-bit two's complement), sign-extended to 8 bits, into the running value of bit `ld_idx`. From the next cycle on, `hard[ld_idx]` shows its sign bit.
- R2: Bit n connects to check (n mod M) and to check ((n mod M) + 1 + floor(n/M)) mod M, where M is the check count (6 by default, with 12 bits). Each pass visits checks 0, 1, …, M-1 in that order, one check per clock cycle.
- R3: The magnitude a bit presents to a check is min(|v|, 7), and its sign is 1 when v < 0. The function f, indexed by magnitude 0..7, is 7, 3, 2, 1, 1, 0, 0, 0; this is round(2·(−ln tanh(q/4))) limited to 7. The message to a connected bit has sign equal to the XOR of the other connected bits' signs. Its magnitude is f(min(sum of f over the other bits' magnitudes, 7)).
- R4: The value a bit sends to the active check is its current running value, unchanged. Each connected bit then adds its message, with all messages of one step computed from the values held before that step. Bits not connected to the active check keep their value.
- R5: Running values are 8-bit two's complement and saturate at +127 and −127; they never wrap.
- R6: An iteration count K in 1..15 runs K full passes. K = 0 runs one pass. `done` rises exactly M·K cycles after the clock edge that samples `start`.
- R7: `done` is high for exactly one cycle per decode. `hard[n]` is always the sign bit of bit n's running value (1 = negative).
- R8: A start pulse that arrives while a decode is running is ignored. It neither restarts nor extends the decode.
- R9: `ld_en` is ignored while a decode is running.
- R10: After reset every running value is zero, `hard` is all zeros and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_en | input | 1 | Write one LLR (honoured only when idle) |
| ld_idx | input | 4 | Bit index of the LLR being written |
| ld_llr | input | 6 | LLR value, two's complement |
| start | input | 1 | Begin a decode (honoured only when idle) |
| iters | input | 4 | Number of passes over all checks |
| hard | output | 12 | Hard decision per bit |
| done | output | 1 | One-cycle pulse when the decode has finished |

## Verification
The bench targets the ways a serial schedule typically goes wrong. If a design used values from before the current pass, or updated bits one step late, its decisions would drift away from the behavioural model on mixed-sign LLR patterns. If it counted passes wrongly, or mishandled a count of zero, `done` would arrive at the wrong cycle or never arrive. Long runs with all-positive and all-negative LLRs drive the sums into saturation; a design that wrapped instead of clamping would flip every hard decision. A second start and a load injected during a decode show whether a design restarts or lets a running decode be corrupted. Either fault would change the latency or the decisions.

// File: rtl/stag_ldpc_dec.sv
module stag_ldpc_dec #(
  parameter int N_BITS = 12,
  parameter int N_CHK  = 6,
  parameter int LLR_W  = 6,
  parameter int SUM_W  = 8,
  parameter int ITW    = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             ld_en,
  input  logic [$clog2(N_BITS)-1:0]        ld_idx,
  input  logic [LLR_W-1:0]                 ld_llr,
  input  logic                             start,
  input  logic [ITW-1:0]                   iters,
  output logic [N_BITS-1:0]                hard,
  output logic                             done
);

  localparam int MAG_W = 3;
  localparam int CHK_W = (N_CHK > 1) ? $clog2(N_CHK) : 1;
  localparam int PS_W  = MAG_W + $clog2(N_BITS + 1);
  localparam logic [MAG_W-1:0] MAG_MAX = {MAG_W{1'b1}};
  localparam logic [SUM_W:0]   SMAX = (SUM_W+1)'((2**(SUM_W-1)) - 1);
  localparam logic [SUM_W:0]   SMIN = -SMAX;
  localparam logic [SUM_W-1:0] VMIN = {1'b1, {(SUM_W-1){1'b0}}};

  function automatic logic [MAG_W-1:0] phi_q(input logic [MAG_W-1:0] q);
    case (q)
      3'd0:    phi_q = 3'd7;
      3'd1:    phi_q = 3'd3;
      3'd2:    phi_q = 3'd2;
      3'd3:    phi_q = 3'd1;
      3'd4:    phi_q = 3'd1;
      default: phi_q = 3'd0;
    endcase
  endfunction

  typedef enum logic {S_IDLE, S_RUN} st_t;

  st_t                st;
  logic [SUM_W-1:0]   rv [N_BITS];
  logic [CHK_W-1:0]   chk;
  logic [ITW-1:0]     it_cnt, it_last;
  logic               done_q;

  logic [N_BITS-1:0]  act, sgn;
  logic [MAG_W-1:0]   ph  [N_BITS];
  logic [SUM_W-1:0]   nxt [N_BITS];
  logic               tot_s;
  logic [PS_W-1:0]    tot_p;

  wire last_chk  = (chk == CHK_W'(N_CHK - 1));
  wire last_step = (st == S_RUN) && last_chk && (it_cnt == it_last);

  for (genvar n = 0; n < N_BITS; n++) begin : g_bit
    localparam int CA = n % N_CHK;
    localparam int CB = (CA + 1 + n / N_CHK) % N_CHK;

    logic [SUM_W-1:0] ab;
    logic [MAG_W-1:0] mg, ex_c, m_mag;
    logic [PS_W-1:0]  ex_p;
    logic             m_s;
    logic [SUM_W:0]   mext, msgv, sum;

    assign act[n] = (chk == CHK_W'(CA)) || (chk == CHK_W'(CB));
    assign sgn[n] = rv[n][SUM_W-1];
    assign ab     = sgn[n] ? -rv[n] : rv[n];
    assign mg     = (ab > SUM_W'(MAG_MAX)) ? MAG_MAX : ab[MAG_W-1:0];
    assign ph[n]  = phi_q(mg);

    assign ex_p   = tot_p - PS_W'(ph[n]);
    assign ex_c   = (ex_p > PS_W'(MAG_MAX)) ? MAG_MAX : ex_p[MAG_W-1:0];
    assign m_mag  = phi_q(ex_c);
    assign m_s    = tot_s ^ sgn[n];
    assign mext   = (SUM_W+1)'(m_mag);
    assign msgv   = m_s ? -mext : mext;
    assign sum    = {rv[n][SUM_W-1], rv[n]} + msgv;
    assign nxt[n] = ($signed(sum) > $signed(SMAX)) ? SMAX[SUM_W-1:0] :
                    ($signed(sum) < $signed(SMIN)) ? SMIN[SUM_W-1:0] :
                    sum[SUM_W-1:0];

    assign hard[n] = rv[n][SUM_W-1];

    a_r4_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_RUN && !act[n]) |=> (rv[n] == $past(rv[n])));
    a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      rv[n] != VMIN);
  end

  always_comb begin
    tot_s = 1'b0;
    tot_p = '0;
    for (int n = 0; n < N_BITS; n++) begin
      if (act[n]) begin
        tot_s = tot_s ^ sgn[n];
        tot_p = tot_p + PS_W'(ph[n]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      chk     <= '0;
      it_cnt  <= '0;
      it_last <= '0;
      done_q  <= 1'b0;
      for (int n = 0; n < N_BITS; n++) rv[n] <= '0;
    end else begin
      done_q <= 1'b0;
      if (st == S_IDLE) begin
        if (ld_en && (int'(ld_idx) < N_BITS))
          rv[ld_idx] <= {{(SUM_W-LLR_W){ld_llr[LLR_W-1]}}, ld_llr};
        if (start) begin
          st      <= S_RUN;
          chk     <= '0;
          it_cnt  <= '0;
          it_last <= (iters == '0) ? '0 : iters - 1'b1;
        end
      end else begin
        for (int n = 0; n < N_BITS; n++)
          if (act[n]) rv[n] <= nxt[n];
        chk <= last_chk ? '0 : chk + 1'b1;
        if (last_chk) it_cnt <= it_cnt + 1'b1;
        if (last_step) begin
          st     <= S_IDLE;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done = done_q;

  a_r2_step_order: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && !last_step) |=>
      (st == S_RUN && chk == (($past(chk) == CHK_W'(N_CHK - 1)) ? '0 : $past(chk) + 1'b1)));
  a_r2_chk_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(chk) < N_CHK);
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  a_r8_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(st) == S_RUN && st == S_IDLE));

endmodule

// File: tb/stag_ldpc_dec_tb.sv
`timescale 1ns/1ps
module stag_ldpc_dec_tb_top;
  localparam int NB = 12, NC = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_en = 1'b0, start = 1'b0;
  logic [3:0] ld_idx = '0, iters = '0;
  logic [5:0] ld_llr = '0;
  logic [NB-1:0] hard;
  logic done;

  stag_ldpc_dec dut_i (.clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx),
    .ld_llr(ld_llr), .start(start), .iters(iters), .hard(hard), .done(done));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  int mv [NB];

  localparam logic [75:0] VEC [6] = '{
    {4'd1, 72'h8A3F210C7E55B19D04},
    {4'd3, 72'h1F0E2D3C4B5A697887},
    {4'd5, 72'hFEDCBA987654321012},
    {4'd2, 72'h0123456789ABCDEF3C},
    {4'd7, 72'hC3A5F00F5AC396E187},
    {4'd4, 72'h7E81BD42E7185AA566}
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int phi_b(input int q);
    real x, e, r;
    int v;
    if (q == 0) return 7;
    x = q / 4.0;
    e = $exp(2.0 * x);
    r = -$ln((e - 1.0) / (e + 1.0));
    v = $rtoi(2.0 * r + 0.5);
    return (v > 7) ? 7 : v;
  endfunction

  function automatic bit linked(input int m, input int n);
    int a = n % NC;
    int b = (a + 1 + n / NC) % NC;
    return (a == m) || (b == m);
  endfunction

  function automatic int mag_b(input int v);
    int a = (v < 0) ? -v : v;
    return (a > 7) ? 7 : a;
  endfunction

  task automatic model_run(input int k);
    int kk = (k == 0) ? 1 : k;
    int snap [NB];
    for (int it = 0; it < kk; it++)
      for (int m = 0; m < NC; m++) begin
        for (int n = 0; n < NB; n++) snap[n] = mv[n];
        for (int n = 0; n < NB; n++) begin
          if (linked(m, n)) begin
            bit s = 0;
            int p = 0, mm, nv;
            for (int j = 0; j < NB; j++)
              if (j != n && linked(m, j)) begin
                s ^= (snap[j] < 0);
                p += phi_b(mag_b(snap[j]));
              end
            mm = phi_b((p > 7) ? 7 : p);
            nv = snap[n] + (s ? -mm : mm);
            mv[n] = (nv > 127) ? 127 : (nv < -127) ? -127 : nv;
          end
        end
      end
  endtask

  function automatic logic [NB-1:0] model_hard();
    logic [NB-1:0] h;
    for (int n = 0; n < NB; n++) h[n] = (mv[n] < 0);
    return h;
  endfunction

  task automatic load_all(input logic [71:0] p);
    for (int n = 0; n < NB; n++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_idx = 4'(n); ld_llr = p[6*n +: 6];
      mv[n] = int'($signed(p[6*n +: 6]));
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic run_dec(input int k, input int inj_start, input int inj_ld, output int lat);
    @(negedge clk);
    iters = 4'(k); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 5000) begin
      @(negedge clk);
      lat++;
      start = (lat == inj_start);
      ld_en = (lat == inj_ld);
      ld_idx = 4'd0;
      ld_llr = (mv[0] < 0) ? 6'h1F : 6'h20;
    end
    start = 1'b0; ld_en = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int lat, kk;
    logic [NB-1:0] exp_h;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(hard == '0, "R10 hard after reset", hard, 0);
    check(done == 1'b0, "R10 done after reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 load visible on hard at once
    load_all(72'h820820820820820820);
    check(hard == 12'hFFF, "R1 loaded signs", hard, 12'hFFF);

    // Vector table: R2 R3 R4 R6 R7
    for (int v = 0; v < 6; v++) begin
      kk = int'(VEC[v][75:72]);
      load_all(VEC[v][71:0]);
      model_run(kk);
      exp_h = model_hard();
      run_dec(kk, -1, -1, lat);
      check(lat == NC * kk, "R6 latency", lat, NC * kk);
      check(hard == exp_h, "R3/R4 R2 decisions", hard, exp_h);
      @(negedge clk);
      check(done == 1'b0, "R7 done one cycle", done, 0);
    end

    // R6 zero iterations acts as one
    load_all(VEC[1][71:0]);
    model_run(0);
    exp_h = model_hard();
    run_dec(0, -1, -1, lat);
    check(lat == NC, "R6 zero count latency", lat, NC);
    check(hard == exp_h, "R6 zero count decisions", hard, exp_h);

    // R8 start during a run is ignored
    load_all(VEC[2][71:0]);
    model_run(3);
    exp_h = model_hard();
    run_dec(3, 5, -1, lat);
    check(lat == NC * 3, "R8 latency with extra start", lat, NC * 3);
    check(hard == exp_h, "R8 decisions with extra start", hard, exp_h);
    repeat (NC * 2) @(negedge clk);
    check(done == 1'b0, "R8 no second done", done, 0);

    // R9 load during a run is ignored
    load_all(VEC[4][71:0]);
    model_run(2);
    exp_h = model_hard();
    run_dec(2, -1, 4, lat);
    check(hard == exp_h, "R9 decisions with load in run", hard, exp_h);
    check(lat == NC * 2, "R9 latency", lat, NC * 2);

    // R5 saturation, positive and negative
    load_all({12{6'h1F}});
    model_run(15);
    run_dec(15, -1, -1, lat);
    check(hard == 12'h000, "R5 positive saturation", hard, 0);
    load_all({12{6'h20}});
    model_run(15);
    run_dec(15, -1, -1, lat);
    check(hard == 12'hFFF, "R5 negative saturation", hard, 12'hFFF);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule